// File: doc/BRIEF.md
# Thread-Steered Periodic Interval Timer

This block is a 32-bit interval timer for a multithreaded processor core. Software programs a limit, a count, a two-bit control word and a mask of hardware threads through a small auxiliary register port. The count climbs toward the limit. On the counting cycle where it equals the limit, it returns to zero, which gives a periodic tick with period limit+1 counting cycles.

When the interrupt-enable control bit is set, each expiry latches a sticky pending flag for every thread currently selected in the mask. Each thread has its own interrupt line, driven by its flag. A control bit can gate counting so that the timer only advances while the CPU is not halted. Any control write clears every pending flag. Clearing a mask bit drops that thread's flag.

Top module: `tsteer_timer`

## Requirements
- R1: After reset the count, control, limit and mask registers read zero and every interrupt line is low.
- R2: A read with the address at 0x21 returns the count, at 0x22 the control word (bits 1:0, upper bits zero), at 0x23 the limit, and at 0xFFFFF850 the thread mask (bits 15:0, upper bits zero). Any other address reads zero. Writes to these addresses load the register at the next clock edge. Mask writes keep only bits 15:0.
- R3: With control bit 1 clear, the count advances by one on every cycle, whatever the halted input shows.
- R4: With control bit 1 set, the count holds on every cycle where the halted input is high, and no expiry happens on such a cycle.
- R5: On a counting cycle where the count equals the limit, the count becomes zero at the next edge and keeps running, so expiries repeat every limit+1 counting cycles.
- R6: A write to the count register loads the written value and takes precedence over advancing. Writing zero restarts the period.
- R7: An expiry while control bit 0 is set raises the pending flag of every thread n whose mask bit n is set. A flag stays high until it is cleared, and interrupt line n shows flag n.
- R8: An expiry while control bit 0 is clear raises no flag.
- R9: Any write to the control register clears all pending flags. This also holds when the write falls on an expiry cycle, in which case no flag is set.
- R10: Clearing mask bit n clears flag n at the same edge. Setting a mask bit raises no interrupt by itself.
- R11: A limit of 0xFFFFFFFF is reached and wraps to zero like any other limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_halted | input | 1 | High on cycles the CPU is halted |
| thr_irq | output | 16 | Per-thread interrupt lines |

## Verification
Two collisions can occur on the same edge: an expiry setting flags while a control or mask write clears them, and an expiry wrapping the count while software writes it. The bench provokes the first on purpose. It loads the count equal to the limit and then writes the control register on exactly the next cycle. It expects all lines to stay low, and a full period later it expects all masked lines to rise. Random traffic adds more such collisions, using small limits and frequent writes. A reference model built from the requirements judges the read data and every interrupt line on each cycle.

// File: rtl/tsteer_timer.sv
`timescale 1ns/1ps
module tsteer_timer #(
  parameter int NTHR = 16,
  parameter int CW   = 32,
  parameter int AW   = 32,
  parameter logic [AW-1:0] A_CNT  = 'h21,
  parameter logic [AW-1:0] A_CTRL = 'h22,
  parameter logic [AW-1:0] A_LIM  = 'h23,
  parameter logic [AW-1:0] A_MASK = 'hFFFFF850
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [CW-1:0]   bus_rdata,
  input  logic            cpu_halted,
  output logic [NTHR-1:0] thr_irq
);
  logic [CW-1:0]   count_q, limit_q;
  logic [1:0]      ctrl_q;
  logic [NTHR-1:0] mask_q, pend_q, mask_nx;
  logic wr_cnt, wr_ctrl, wr_lim, wr_mask, tick, hit;

  assign wr_cnt  = bus_we && (bus_addr == A_CNT);
  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_lim  = bus_we && (bus_addr == A_LIM);
  assign wr_mask = bus_we && (bus_addr == A_MASK);

  assign tick    = ctrl_q[1] ? ~cpu_halted : 1'b1;
  assign hit     = tick && (count_q == limit_q);
  assign mask_nx = wr_mask ? bus_wdata[NTHR-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
      ctrl_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_cnt)    count_q <= bus_wdata;
      else if (hit)  count_q <= '0;
      else if (tick) count_q <= count_q + 1'b1;
      if (wr_lim)  limit_q <= bus_wdata;
      if (wr_ctrl) ctrl_q  <= bus_wdata[1:0];
      mask_q <= mask_nx;
      if (wr_ctrl) pend_q <= '0;
      else         pend_q <= (pend_q | ({NTHR{hit & ctrl_q[0]}} & mask_q)) & mask_nx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CNT)       bus_rdata = count_q;
    else if (bus_addr == A_CTRL) bus_rdata = CW'(ctrl_q);
    else if (bus_addr == A_LIM)  bus_rdata = limit_q;
    else if (bus_addr == A_MASK) bus_rdata = CW'(mask_q);
  end

  assign thr_irq = pend_q;
endmodule

module tsteer_timer_chk #(
  parameter int NTHR = 16,
  parameter int CW   = 32,
  parameter int AW   = 32,
  parameter logic [AW-1:0] A_CNT  = 'h21,
  parameter logic [AW-1:0] A_CTRL = 'h22
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic            cpu_halted,
  input logic [CW-1:0]   count_q,
  input logic [CW-1:0]   limit_q,
  input logic [1:0]      ctrl_q,
  input logic [NTHR-1:0] mask_q,
  input logic [NTHR-1:0] thr_irq
);
  logic cw, kw;
  assign cw = bus_we && (bus_addr == A_CNT);
  assign kw = bus_we && (bus_addr == A_CTRL);

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !cw && count_q != limit_q) |=> count_q == $past(count_q) + 1'b1);
  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && cpu_halted && !cw) |=> $stable(count_q));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl_q[1] || !cpu_halted) && !cw && count_q == limit_q) |=> count_q == '0);
  assert_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> (thr_irq & ~$past(thr_irq)) == '0);
  assert_ctrl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kw |=> thr_irq == '0);
  assert_mask_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_irq & ~mask_q) == '0);
endmodule

bind tsteer_timer tsteer_timer_chk #(
  .NTHR(NTHR), .CW(CW), .AW(AW), .A_CNT(A_CNT), .A_CTRL(A_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .cpu_halted(cpu_halted), .count_q(count_q), .limit_q(limit_q),
  .ctrl_q(ctrl_q), .mask_q(mask_q), .thr_irq(thr_irq)
);

// File: tb/sim_tsteer_timer.sv
`timescale 1ns/1ps
module sim_tsteer_timer;
  localparam logic [31:0] A_CNT = 32'h21, A_CTRL = 32'h22, A_LIM = 32'h23, A_MASK = 32'hFFFFF850;

  logic clk = 0, rst_n = 0, bus_we = 0, cpu_halted = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [15:0] thr_irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_cnt = 0, m_lim = 0;
  logic [1:0]  m_ctrl = 0;
  logic [15:0] m_mask = 0, m_pend = 0;

  always #10 clk = ~clk;

  tsteer_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cpu_halted(cpu_halted), .thr_irq(thr_irq));

  function automatic logic [31:0] model_read(logic [31:0] a);
    if (a == A_CNT)  return m_cnt;
    if (a == A_CTRL) return {30'd0, m_ctrl};
    if (a == A_LIM)  return m_lim;
    if (a == A_MASK) return {16'd0, m_mask};
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [31:0] a, logic [31:0] wd, logic h, bit rd, string tag);
    logic tk, ex;
    logic [31:0] nc;
    logic [15:0] nm, np;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; cpu_halted = h;
    #2;
    if (rd) chk(tag, bus_rdata, model_read(a));
    chk("R7 irq", {16'd0, thr_irq}, {16'd0, m_pend});
    tk = m_ctrl[1] ? !h : 1'b1;
    ex = tk && (m_cnt == m_lim);
    nc = (we && a == A_CNT) ? wd : (ex ? 32'd0 : (tk ? m_cnt + 1 : m_cnt));
    nm = (we && a == A_MASK) ? wd[15:0] : m_mask;
    np = (we && a == A_CTRL) ? 16'd0 : ((m_pend | ((ex && m_ctrl[0]) ? m_mask : 16'd0)) & nm);
    @(posedge clk); #1;
    m_cnt = nc; m_mask = nm; m_pend = np;
    if (we && a == A_LIM)  m_lim = wd;
    if (we && a == A_CTRL) m_ctrl = wd[1:0];
    bus_we = 0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d); cyc(1, a, d, 0, 0, ""); endtask
  task automatic rd(logic [31:0] a, logic h, string tag); cyc(0, a, 0, h, 1, tag); endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    rd(A_CNT, 0, "R1"); rd(A_CTRL, 0, "R1"); rd(A_LIM, 0, "R1"); rd(A_MASK, 0, "R1");
    chk("R1", {16'd0, thr_irq}, 32'd0);
    // R2
    wr(A_LIM, 32'h1234_5678); rd(A_LIM, 0, "R2");
    chk("R2", model_read(A_LIM), 32'h1234_5678);
    wr(A_MASK, 32'hABCD_1234); rd(A_MASK, 0, "R2");
    chk("R2", model_read(A_MASK), 32'h0000_1234);
    rd(32'h24, 0, "R2"); rd(32'h0, 0, "R2");
    // R3: free counting ignores halt
    wr(A_MASK, 0); wr(A_CNT, 0);
    for (int i = 0; i < 6; i++) rd(A_CNT, i[0], "R3");
    chk("R3", model_read(A_CNT), 32'd6);
    // R4: halt gating
    wr(A_CTRL, 2); wr(A_CNT, 10);
    for (int i = 0; i < 4; i++) rd(A_CNT, 1, "R4");
    chk("R4", model_read(A_CNT), 32'd10);
    rd(A_CNT, 0, "R4"); chk("R4", model_read(A_CNT), 32'd11);
    // R5: wrap with limit 5
    wr(A_CTRL, 0); wr(A_LIM, 5); wr(A_CNT, 0);
    for (int i = 0; i < 14; i++) rd(A_CNT, 0, "R5");
    chk("R5", model_read(A_CNT), 32'd2);
    // R6: count write overrides advance
    wr(A_CNT, 3); rd(A_CNT, 0, "R6"); wr(A_CNT, 0); rd(A_CNT, 0, "R6");
    // R11: full-range limit
    wr(A_LIM, 32'hFFFF_FFFF); wr(A_CNT, 32'hFFFF_FFFE);
    for (int i = 0; i < 3; i++) rd(A_CNT, 0, "R11");
    chk("R11", model_read(A_CNT), 32'd1);
    // R7: steered expiry
    wr(A_MASK, 32'h00A5); wr(A_LIM, 3); wr(A_CNT, 0); wr(A_CTRL, 3);
    for (int i = 0; i < 5; i++) rd(A_CNT, 0, "R7");
    chk("R7", {16'd0, thr_irq}, 32'h00A5);
    // R10: clearing a mask bit drops its flag; setting one raises nothing
    wr(A_MASK, 32'h00A4); chk("R10", {16'd0, thr_irq}, 32'h00A4);
    wr(A_CTRL, 2); wr(A_MASK, 32'h00FF); chk("R10", {16'd0, thr_irq}, 32'h0000);
    // R8: expiry with interrupt enable clear
    for (int i = 0; i < 10; i++) rd(A_CNT, 0, "R8");
    chk("R8", {16'd0, thr_irq}, 32'h0000);
    // R9: control write on the expiry cycle
    wr(A_MASK, 32'hFFFF); wr(A_LIM, 6); wr(A_CTRL, 3); wr(A_CNT, 6);
    wr(A_CTRL, 3);
    chk("R9", {16'd0, thr_irq}, 32'h0000);
    for (int i = 0; i < 7; i++) rd(A_CNT, 0, "R9");
    chk("R7", {16'd0, thr_irq}, 32'hFFFF);
    wr(A_CTRL, 1); chk("R9", {16'd0, thr_irq}, 32'h0000);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] ra;
      logic h;
      op = $urandom % 16;
      h = ($urandom % 3) == 0;
      case (op % 5)
        0: ra = A_CNT; 1: ra = A_CTRL; 2: ra = A_LIM; 3: ra = A_MASK;
        default: ra = 32'h30 + ($urandom % 4);
      endcase
      case (op)
        0: cyc(1, A_CNT, $urandom % 10, h, 1, "R6 rand");
        1: cyc(1, A_CTRL, $urandom % 4, h, 1, "R9 rand");
        2: cyc(1, A_LIM, $urandom % 9, h, 1, "R5 rand");
        3: cyc(1, A_MASK, $urandom, h, 1, "R10 rand");
        default: cyc(0, ra, 0, h, 1, "R2 rand");
      endcase
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule